// File: doc/BRIEF.md
# USB Endpoint Buffer Handshake Controller

This block owns the packet buffers of one bulk/interrupt IN endpoint, one bulk/interrupt OUT endpoint (64 bytes each) and the 8-byte setup buffer of a full-speed USB peripheral. On one side it sees abstract events from a serial interface engine: IN tokens, received bytes, the end of an OUT or SETUP packet with a good/bad flag and the received data PID, host ACK or timeout after IN data, and status-stage tokens. On the other side a CPU loads and arms IN data, drains OUT and SETUP data, clears requests and grants the status stage. From these events the block picks the handshake, keeps the data toggles and raises buffer-available, data-available and setup-available requests.

Three state machines make up the block. The IN machine has three states. IN_IDLE is unarmed and buffer-available, and an arm pulse moves it to IN_ARMED. In IN_ARMED an IN token sends DATA and moves to IN_SENT. From IN_SENT, ACK returns to IN_IDLE, a timeout goes back to IN_ARMED, and a repeated IN token resends. The OUT machine has OUT_OPEN, which accepts a good packet with the expected toggle and moves to OUT_HELD. OUT_HELD returns to OUT_OPEN when the CPU clears the data-available request. The setup machine has SU_IDLE and SU_WAIT, and any good SETUP enters SU_WAIT. The CPU's acknowledge-status grant moves SU_WAIT to SU_READY, and the status ACK moves SU_READY back to SU_IDLE. Each handshake is registered and appears for one cycle, in the cycle after its event.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After reset the IN buffer-available request is 1, data-available, setup-available and acknowledge-status are 0, both toggles are 0 and no handshake is driven.
- R2: In IN_IDLE each CPU load writes the next IN buffer byte, starting at 0. An arm pulse with count N leaves IN_IDLE, drops buffer-available and sets the transmit length to min(N,64). The next IN token is answered with hs_code 1 (DATA), and tx_byte then presents the loaded bytes in load order, advancing on each tx_rd.
- R3: An IN token in IN_IDLE is answered with hs_code 2 (NAK).
- R4: A host ACK in IN_SENT returns to IN_IDLE, raises buffer-available and inverts the IN toggle.
- R5: A timeout in IN_SENT re-arms the endpoint. The next IN token gets DATA again with the same bytes, length and toggle.
- R6: CPU loads while the IN endpoint is armed or sent are ignored and do not alter the data resent.
- R7: A good OUT packet whose PID bit equals the OUT toggle in OUT_OPEN is answered hs_code 3 (ACK). It raises data-available, latches the byte count (0 to 64), inverts the OUT toggle and exposes the bytes in order on out_rdata, advancing on each cpu_out_rd.
- R8: A bad OUT packet gets no handshake and changes neither data-available nor the OUT toggle.
- R9: A good OUT packet whose PID bit differs from the OUT toggle is answered ACK and discarded, with no data-available and no toggle change.
- R10: Any OUT packet in OUT_HELD gets NAK and leaves the held bytes and count intact. Clearing data-available returns to OUT_OPEN.
- R11: A good SETUP packet stores its 8 bytes, is answered ACK, raises setup-available (cleared by cpu_sud_clr) and clears any earlier acknowledge-status grant. The bytes are read in arrival order on sud_rdata, advancing on cpu_sud_rd.
- R12: Status tokens get NAK until the CPU grants acknowledge-status in SU_WAIT. The next status token then gets ACK, and the grant clears itself.
- R13: cpu_clr_in_tog and cpu_clr_out_tog force the respective toggle to 0.
- R14: At most one source drives a handshake in a cycle. hs_code is 1 DATA, 2 NAK, 3 ACK and is meaningful only while hs_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sie_in_tok | input | 1 | IN token addressed to the data IN endpoint |
| sie_host_ack | input | 1 | Host ACK after IN data |
| sie_host_tmo | input | 1 | No ACK after IN data (timeout or error) |
| sie_tx_rd | input | 1 | Advance the transmit byte pointer |
| sie_rx_valid | input | 1 | Received byte strobe |
| sie_rx_setup | input | 1 | Received byte belongs to a SETUP packet |
| sie_rx_byte | input | 8 | Received byte |
| sie_out_end | input | 1 | End of OUT data packet |
| sie_out_ok | input | 1 | OUT packet CRC/length good |
| sie_out_pid | input | 1 | OUT data PID toggle bit (DATA0=0, DATA1=1) |
| sie_setup_end | input | 1 | End of SETUP data packet |
| sie_setup_ok | input | 1 | SETUP packet good |
| sie_status_tok | input | 1 | Status-stage token of a control transfer |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 1 DATA, 2 NAK, 3 ACK |
| tx_byte | output | 8 | IN byte at the transmit pointer |
| tx_len | output | 7 | IN packet length |
| tx_tog | output | 1 | IN data PID toggle |
| cpu_in_wr | input | 1 | Load one IN byte |
| cpu_in_wdata | input | 8 | IN byte to load |
| cpu_in_arm | input | 1 | Arm the IN endpoint |
| cpu_in_cnt | input | 7 | IN byte count written at arm |
| cpu_out_rd | input | 1 | Advance the OUT read pointer |
| cpu_out_clr | input | 1 | Clear OUT data-available (re-arm) |
| cpu_sud_rd | input | 1 | Advance the setup read pointer |
| cpu_sud_clr | input | 1 | Clear setup-available |
| cpu_ackstat_set | input | 1 | Grant status-stage acknowledge |
| cpu_clr_in_tog | input | 1 | Reset IN toggle |
| cpu_clr_out_tog | input | 1 | Reset OUT toggle |
| in_bav | output | 1 | IN buffer-available request |
| in_tog | output | 1 | IN toggle |
| out_dav | output | 1 | OUT data-available request |
| out_tog | output | 1 | OUT expected toggle |
| out_cnt | output | 7 | Byte count of held OUT packet |
| out_rdata | output | 8 | OUT byte at the read pointer |
| sud_av | output | 1 | Setup-available request |
| sud_rdata | output | 8 | Setup byte at the read pointer |
| ackstat | output | 1 | Status acknowledge granted and pending |

## Verification
The hardest situation to reach is a retried IN transfer that still carries its first data after CPU load attempts have been made in between. Reaching it needs a load, an arm, a DATA answer, a timeout, a stray CPU write while armed and a second IN token, in that order. A directed sequence builds this chain explicitly and then finishes with an ACK so that the toggle flip is observed. OUT packets arriving while a held packet is undrained, and duplicate-toggle packets, are likewise set up by directed steps before a long random run of single events is compared against a behavioural model on every clock.

// File: rtl/ep_pkg.sv
package ep_pkg;
    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_DATA = 2'd1,
        HS_NAK  = 2'd2,
        HS_ACK  = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        IN_IDLE  = 2'd0,
        IN_ARMED = 2'd1,
        IN_SENT  = 2'd2
    } in_st_e;

    typedef enum logic {
        OUT_OPEN = 1'b0,
        OUT_HELD = 1'b1
    } out_st_e;

    typedef enum logic [1:0] {
        SU_IDLE  = 2'd0,
        SU_WAIT  = 2'd1,
        SU_READY = 2'd2
    } su_st_e;
endpackage

// File: rtl/ep_in_ctrl.sv
module ep_in_ctrl
    import ep_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic          host_ack,
    input  logic          host_tmo,
    input  logic          tx_rd,
    input  logic          cpu_wr,
    input  logic [7:0]    cpu_wdata,
    input  logic          cpu_arm,
    input  logic [CW-1:0] cpu_cnt,
    input  logic          clr_tog,
    output logic          hs_vld,
    output hs_e           hs_code,
    output logic [7:0]    tx_byte,
    output logic [CW-1:0] tx_len,
    output logic          tx_tog,
    output logic          bav
);
    in_st_e        st, st_nx;
    logic          hv_nx;
    hs_e           hc_nx;
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          tog;
    logic          load_ok;
    logic          arm_now;
    logic          acked;
    logic [CW-1:0] cnt_clamped;

    assign cnt_clamped = (cpu_cnt > CW'(DEPTH)) ? CW'(DEPTH) : cpu_cnt;

    // next state and handshake decision
    always_comb begin
        st_nx = st;
        hv_nx = 1'b0;
        hc_nx = HS_NONE;
        unique case (st)
            IN_IDLE: begin
                if (tok_in) begin
                    hv_nx = 1'b1;
                    hc_nx = HS_NAK;
                end else if (cpu_arm) begin
                    st_nx = IN_ARMED;
                end
            end
            IN_ARMED: begin
                if (tok_in) begin
                    hv_nx = 1'b1;
                    hc_nx = HS_DATA;
                    st_nx = IN_SENT;
                end
            end
            IN_SENT: begin
                if (host_ack) begin
                    st_nx = IN_IDLE;
                end else if (host_tmo) begin
                    st_nx = IN_ARMED;
                end else if (tok_in) begin
                    hv_nx = 1'b1;
                    hc_nx = HS_DATA;
                end
            end
            default: st_nx = IN_IDLE;
        endcase
    end

    assign load_ok = (st == IN_IDLE) && cpu_wr;
    assign arm_now = (st == IN_IDLE) && (st_nx == IN_ARMED);
    assign acked   = (st == IN_SENT) && host_ack;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= IN_IDLE;
        else        st <= st_nx;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_vld  <= 1'b0;
            hs_code <= HS_NONE;
            wp      <= '0;
            rp      <= '0;
            tx_len  <= '0;
            tog     <= 1'b0;
        end else begin
            hs_vld  <= hv_nx;
            hs_code <= hc_nx;
            if (arm_now) begin
                wp     <= '0;
                tx_len <= cnt_clamped;
            end else if (load_ok) begin
                wp <= wp + 1'b1;
            end
            if (hv_nx && hc_nx == HS_DATA) rp <= '0;
            else if (tx_rd)                rp <= rp + 1'b1;
            if (acked)        tog <= ~tog;
            else if (clr_tog) tog <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load_ok) mem[wp] <= cpu_wdata;
    end

    assign tx_byte = mem[rp];
    assign tx_tog  = tog;
    assign bav     = (st == IN_IDLE);

    assert_arm_clears_bav_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IN_IDLE && cpu_arm && !tok_in) |=> (!bav && tx_len <= CW'(DEPTH)));
    assert_nak_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IN_IDLE && tok_in) |=> (hs_vld && hs_code == HS_NAK));
    assert_ack_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IN_SENT && host_ack) |=> (bav && tog != $past(tog)));
    assert_retry_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IN_SENT && !host_ack && host_tmo && !clr_tog) |=> (!bav && $stable(tog) && $stable(tx_len)));
    assert_data_when_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IN_ARMED && tok_in) |=> (hs_vld && hs_code == HS_DATA));
endmodule

// File: rtl/ep_out_ctrl.sv
module ep_out_ctrl
    import ep_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_setup,
    input  logic [7:0]    rx_byte,
    input  logic          pkt_end,
    input  logic          pkt_ok,
    input  logic          pkt_pid,
    input  logic          cpu_rd,
    input  logic          cpu_clr,
    input  logic          clr_tog,
    output logic          hs_vld,
    output hs_e           hs_code,
    output logic          dav,
    output logic          tog,
    output logic [CW-1:0] cnt,
    output logic [7:0]    rdata
);
    out_st_e       st, st_nx;
    logic          hv_nx;
    hs_e           hc_nx;
    logic          accept;
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] wc;
    logic [AW-1:0] rp;
    logic          store;

    always_comb begin
        st_nx  = st;
        hv_nx  = 1'b0;
        hc_nx  = HS_NONE;
        accept = 1'b0;
        unique case (st)
            OUT_OPEN: begin
                if (pkt_end && pkt_ok) begin
                    hv_nx = 1'b1;
                    hc_nx = HS_ACK;
                    if (pkt_pid == tog) begin
                        accept = 1'b1;
                        st_nx  = OUT_HELD;
                    end
                end
            end
            OUT_HELD: begin
                if (pkt_end) begin
                    hv_nx = 1'b1;
                    hc_nx = HS_NAK;
                end else if (cpu_clr) begin
                    st_nx = OUT_OPEN;
                end
            end
            default: st_nx = OUT_OPEN;
        endcase
    end

    assign store = (st == OUT_OPEN) && rx_valid && !rx_setup && (wc < CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= OUT_OPEN;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_vld  <= 1'b0;
            hs_code <= HS_NONE;
            wc      <= '0;
            rp      <= '0;
            cnt     <= '0;
            tog     <= 1'b0;
        end else begin
            hs_vld  <= hv_nx;
            hs_code <= hc_nx;
            if (st == OUT_OPEN && pkt_end) wc <= '0;
            else if (store)                wc <= wc + 1'b1;
            if (accept) begin
                cnt <= wc;
                rp  <= '0;
            end else if (cpu_rd) begin
                rp <= rp + 1'b1;
            end
            if (accept)       tog <= ~tog;
            else if (clr_tog) tog <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (store) mem[wc[AW-1:0]] <= rx_byte;
    end

    assign rdata = mem[rp];
    assign dav   = (st == OUT_HELD);

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OUT_OPEN && pkt_end && pkt_ok && pkt_pid == tog) |=> (dav && hs_code == HS_ACK && tog != $past(tog)));
    assert_bad_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OUT_OPEN && pkt_end && !pkt_ok) |=> (!hs_vld && !dav));
    assert_dup_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OUT_OPEN && pkt_end && pkt_ok && pkt_pid != tog) |=> (hs_vld && hs_code == HS_ACK && !dav));
    assert_nak_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OUT_HELD && pkt_end) |=> (hs_vld && hs_code == HS_NAK && dav && $stable(cnt)));
endmodule

// File: rtl/ep_setup_ctrl.sv
module ep_setup_ctrl
    import ep_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       rx_setup,
    input  logic [7:0] rx_byte,
    input  logic       pkt_end,
    input  logic       pkt_ok,
    input  logic       status_tok,
    input  logic       cpu_rd,
    input  logic       cpu_clr,
    input  logic       ackstat_set,
    output logic       hs_vld,
    output hs_e        hs_code,
    output logic       av,
    output logic [7:0] rdata,
    output logic       ackstat
);
    su_st_e        st, st_nx;
    logic          hv_nx;
    hs_e           hc_nx;
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          store;
    logic          taken;

    assign store = rx_valid && rx_setup;
    assign taken = pkt_end && pkt_ok;

    always_comb begin
        st_nx = st;
        hv_nx = 1'b0;
        hc_nx = HS_NONE;
        unique case (st)
            SU_IDLE: begin
                if (status_tok) begin
                    hv_nx = 1'b1;
                    hc_nx = HS_NAK;
                end
            end
            SU_WAIT: begin
                if (status_tok) begin
                    hv_nx = 1'b1;
                    hc_nx = HS_NAK;
                end else if (ackstat_set) begin
                    st_nx = SU_READY;
                end
            end
            SU_READY: begin
                if (status_tok) begin
                    hv_nx = 1'b1;
                    hc_nx = HS_ACK;
                    st_nx = SU_IDLE;
                end
            end
            default: st_nx = SU_IDLE;
        endcase
        if (pkt_end) begin
            hv_nx = pkt_ok;
            hc_nx = pkt_ok ? HS_ACK : HS_NONE;
            if (pkt_ok) st_nx = SU_WAIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SU_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_vld  <= 1'b0;
            hs_code <= HS_NONE;
            wp      <= '0;
            rp      <= '0;
            av      <= 1'b0;
        end else begin
            hs_vld  <= hv_nx;
            hs_code <= hc_nx;
            if (pkt_end)    wp <= '0;
            else if (store) wp <= wp + 1'b1;
            if (taken)       rp <= '0;
            else if (cpu_rd) rp <= rp + 1'b1;
            if (taken)        av <= 1'b1;
            else if (cpu_clr) av <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (store) mem[wp] <= rx_byte;
    end

    assign rdata   = mem[rp];
    assign ackstat = (st == SU_READY);

    assert_setup_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (av && hs_vld && hs_code == HS_ACK && !ackstat));
    assert_status_nak_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ackstat && status_tok && !pkt_end) |=> (hs_vld && hs_code == HS_NAK));
    assert_status_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ackstat && status_tok && !pkt_end) |=> (hs_vld && hs_code == HS_ACK && !ackstat));
endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
    import ep_pkg::*;
#(
    parameter int BUF_DEPTH = 64,
    parameter int SUD_DEPTH = 8,
    localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sie_in_tok,
    input  logic             sie_host_ack,
    input  logic             sie_host_tmo,
    input  logic             sie_tx_rd,
    input  logic             sie_rx_valid,
    input  logic             sie_rx_setup,
    input  logic [7:0]       sie_rx_byte,
    input  logic             sie_out_end,
    input  logic             sie_out_ok,
    input  logic             sie_out_pid,
    input  logic             sie_setup_end,
    input  logic             sie_setup_ok,
    input  logic             sie_status_tok,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic [7:0]       tx_byte,
    output logic [CNT_W-1:0] tx_len,
    output logic             tx_tog,
    input  logic             cpu_in_wr,
    input  logic [7:0]       cpu_in_wdata,
    input  logic             cpu_in_arm,
    input  logic [CNT_W-1:0] cpu_in_cnt,
    input  logic             cpu_out_rd,
    input  logic             cpu_out_clr,
    input  logic             cpu_sud_rd,
    input  logic             cpu_sud_clr,
    input  logic             cpu_ackstat_set,
    input  logic             cpu_clr_in_tog,
    input  logic             cpu_clr_out_tog,
    output logic             in_bav,
    output logic             in_tog,
    output logic             out_dav,
    output logic             out_tog,
    output logic [CNT_W-1:0] out_cnt,
    output logic [7:0]       out_rdata,
    output logic             sud_av,
    output logic [7:0]       sud_rdata,
    output logic             ackstat
);
    logic in_hv, out_hv, su_hv;
    hs_e  in_hc, out_hc, su_hc;
    hs_e  hc_sel;

    ep_in_ctrl #(.DEPTH(BUF_DEPTH)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_in    (sie_in_tok),
        .host_ack  (sie_host_ack),
        .host_tmo  (sie_host_tmo),
        .tx_rd     (sie_tx_rd),
        .cpu_wr    (cpu_in_wr),
        .cpu_wdata (cpu_in_wdata),
        .cpu_arm   (cpu_in_arm),
        .cpu_cnt   (cpu_in_cnt),
        .clr_tog   (cpu_clr_in_tog),
        .hs_vld    (in_hv),
        .hs_code   (in_hc),
        .tx_byte   (tx_byte),
        .tx_len    (tx_len),
        .tx_tog    (tx_tog),
        .bav       (in_bav)
    );

    ep_out_ctrl #(.DEPTH(BUF_DEPTH)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (sie_rx_valid),
        .rx_setup (sie_rx_setup),
        .rx_byte  (sie_rx_byte),
        .pkt_end  (sie_out_end),
        .pkt_ok   (sie_out_ok),
        .pkt_pid  (sie_out_pid),
        .cpu_rd   (cpu_out_rd),
        .cpu_clr  (cpu_out_clr),
        .clr_tog  (cpu_clr_out_tog),
        .hs_vld   (out_hv),
        .hs_code  (out_hc),
        .dav      (out_dav),
        .tog      (out_tog),
        .cnt      (out_cnt),
        .rdata    (out_rdata)
    );

    ep_setup_ctrl #(.DEPTH(SUD_DEPTH)) u_setup (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (sie_rx_valid),
        .rx_setup    (sie_rx_setup),
        .rx_byte     (sie_rx_byte),
        .pkt_end     (sie_setup_end),
        .pkt_ok      (sie_setup_ok),
        .status_tok  (sie_status_tok),
        .cpu_rd      (cpu_sud_rd),
        .cpu_clr     (cpu_sud_clr),
        .ackstat_set (cpu_ackstat_set),
        .hs_vld      (su_hv),
        .hs_code     (su_hc),
        .av          (sud_av),
        .rdata       (sud_rdata),
        .ackstat     (ackstat)
    );

    always_comb begin
        if (in_hv)       hc_sel = in_hc;
        else if (out_hv) hc_sel = out_hc;
        else if (su_hv)  hc_sel = su_hc;
        else             hc_sel = HS_NONE;
    end

    assign in_tog   = tx_tog;
    assign hs_valid = in_hv | out_hv | su_hv;
    assign hs_code  = hc_sel;

    assert_one_source_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_hv, out_hv, su_hv}));
    assert_code_nonzero_R14: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> (hs_code != 2'd0));
endmodule

// File: tb/usb_ep_hs_ctrl_tb.sv
module usb_ep_hs_ctrl_tb;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sie_in_tok = 0, sie_host_ack = 0, sie_host_tmo = 0, sie_tx_rd = 0;
    logic sie_rx_valid = 0, sie_rx_setup = 0;
    logic [7:0] sie_rx_byte = 0;
    logic sie_out_end = 0, sie_out_ok = 0, sie_out_pid = 0;
    logic sie_setup_end = 0, sie_setup_ok = 0, sie_status_tok = 0;
    logic cpu_in_wr = 0, cpu_in_arm = 0, cpu_out_rd = 0, cpu_out_clr = 0;
    logic [7:0] cpu_in_wdata = 0;
    logic [6:0] cpu_in_cnt = 0;
    logic cpu_sud_rd = 0, cpu_sud_clr = 0, cpu_ackstat_set = 0;
    logic cpu_clr_in_tog = 0, cpu_clr_out_tog = 0;
    logic hs_valid, tx_tog, in_bav, in_tog, out_dav, out_tog, sud_av, ackstat;
    logic [1:0] hs_code;
    logic [7:0] tx_byte, out_rdata, sud_rdata;
    logic [6:0] tx_len, out_cnt;

    always #(CLK_P/2) clk = ~clk;

    usb_ep_hs_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .sie_in_tok(sie_in_tok), .sie_host_ack(sie_host_ack), .sie_host_tmo(sie_host_tmo),
        .sie_tx_rd(sie_tx_rd), .sie_rx_valid(sie_rx_valid), .sie_rx_setup(sie_rx_setup),
        .sie_rx_byte(sie_rx_byte), .sie_out_end(sie_out_end), .sie_out_ok(sie_out_ok),
        .sie_out_pid(sie_out_pid), .sie_setup_end(sie_setup_end), .sie_setup_ok(sie_setup_ok),
        .sie_status_tok(sie_status_tok), .hs_valid(hs_valid), .hs_code(hs_code),
        .tx_byte(tx_byte), .tx_len(tx_len), .tx_tog(tx_tog),
        .cpu_in_wr(cpu_in_wr), .cpu_in_wdata(cpu_in_wdata), .cpu_in_arm(cpu_in_arm),
        .cpu_in_cnt(cpu_in_cnt), .cpu_out_rd(cpu_out_rd), .cpu_out_clr(cpu_out_clr),
        .cpu_sud_rd(cpu_sud_rd), .cpu_sud_clr(cpu_sud_clr), .cpu_ackstat_set(cpu_ackstat_set),
        .cpu_clr_in_tog(cpu_clr_in_tog), .cpu_clr_out_tog(cpu_clr_out_tog),
        .in_bav(in_bav), .in_tog(in_tog), .out_dav(out_dav), .out_tog(out_tog),
        .out_cnt(out_cnt), .out_rdata(out_rdata), .sud_av(sud_av), .sud_rdata(sud_rdata),
        .ackstat(ackstat)
    );

    int nchk = 0, nerr = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int   m_ist = 0, m_len = 0, m_inw = 0, m_inr = 0;
    bit   m_intog = 0;
    byte  m_inbuf [64];
    int   m_ow = 0, m_or = 0, m_ocnt = 0;
    bit   m_dav = 0, m_otog = 0;
    byte  m_outbuf [64];
    int   m_sw = 0, m_sr = 0, m_su = 0;
    bit   m_sav = 0;
    byte  m_sud [8];
    bit   m_hv = 0;
    int   m_hc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ist = 0; m_len = 0; m_inw = 0; m_inr = 0; m_intog = 0;
            m_ow = 0; m_or = 0; m_ocnt = 0; m_dav = 0; m_otog = 0;
            m_sw = 0; m_sr = 0; m_su = 0; m_sav = 0; m_hv = 0; m_hc = 0;
        end else begin
            m_hv = 0; m_hc = 0;
            // IN side
            if (sie_in_tok) begin
                if (m_ist == 0) begin m_hv = 1; m_hc = 2; end
                else begin m_hv = 1; m_hc = 1; m_ist = 2; m_inr = 0; end
            end else if (cpu_in_arm && m_ist == 0) begin
                m_ist = 1; m_inw = 0; m_len = (cpu_in_cnt > 64) ? 64 : cpu_in_cnt;
            end else if (cpu_in_wr && m_ist == 0) begin
                m_inbuf[m_inw] = cpu_in_wdata; m_inw = (m_inw + 1) % 64;
            end else if (sie_host_ack && m_ist == 2) begin
                m_ist = 0; m_intog = !m_intog;
            end else if (sie_host_tmo && m_ist == 2) begin
                m_ist = 1;
            end else if (sie_tx_rd) begin
                m_inr = (m_inr + 1) % 64;
            end else if (cpu_clr_in_tog) begin
                m_intog = 0;
            end
            // OUT side
            if (sie_rx_valid && !sie_rx_setup && !m_dav && m_ow < 64) begin
                m_outbuf[m_ow] = sie_rx_byte; m_ow++;
            end
            if (sie_out_end) begin
                if (m_dav) begin m_hv = 1; m_hc = 2; end
                else begin
                    if (sie_out_ok) begin
                        m_hv = 1; m_hc = 3;
                        if (sie_out_pid == m_otog) begin
                            m_dav = 1; m_ocnt = m_ow; m_or = 0; m_otog = !m_otog;
                        end
                    end
                    m_ow = 0;
                end
            end
            if (cpu_out_clr) m_dav = 0;
            if (cpu_out_rd) m_or = (m_or + 1) % 64;
            if (cpu_clr_out_tog) m_otog = 0;
            // setup side
            if (sie_rx_valid && sie_rx_setup) begin
                m_sud[m_sw] = sie_rx_byte; m_sw = (m_sw + 1) % 8;
            end
            if (sie_setup_end) begin
                m_sw = 0;
                if (sie_setup_ok) begin
                    m_hv = 1; m_hc = 3; m_sav = 1; m_sr = 0; m_su = 1;
                end
            end
            if (sie_status_tok) begin
                m_hv = 1;
                if (m_su == 2) begin m_hc = 3; m_su = 0; end
                else m_hc = 2;
            end
            if (cpu_ackstat_set && m_su == 1) m_su = 2;
            if (cpu_sud_rd) m_sr = (m_sr + 1) % 8;
            if (cpu_sud_clr) m_sav = 0;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(hs_valid == m_hv && (!m_hv || hs_code == m_hc), "R14 handshake",
                {hs_valid, hs_code}, {m_hv, m_hc[1:0]});
            chk(in_bav == (m_ist == 0) && in_tog == m_intog, "R4 in flags",
                {in_bav, in_tog}, {(m_ist == 0), m_intog});
            chk(tx_len == m_len && tx_tog == m_intog, "R2 tx len/tog", tx_len, m_len);
            if (m_ist == 2) chk(tx_byte == m_inbuf[m_inr], "R5 tx byte", tx_byte, m_inbuf[m_inr]);
            chk(out_dav == m_dav && out_tog == m_otog, "R7 out flags",
                {out_dav, out_tog}, {m_dav, m_otog});
            if (m_dav) begin
                chk(out_cnt == m_ocnt, "R7 out count", out_cnt, m_ocnt);
                chk(out_rdata == m_outbuf[m_or], "R10 out data", out_rdata, m_outbuf[m_or]);
            end
            chk(sud_av == m_sav && ackstat == (m_su == 2), "R12 setup flags",
                {sud_av, ackstat}, {m_sav, (m_su == 2)});
            if (m_sav) chk(sud_rdata == m_sud[m_sr], "R11 setup data", sud_rdata, m_sud[m_sr]);
        end
    end

    // one event for one cycle; returns at the following falling edge
    task automatic op(input int kind, input int arg);
        case (kind)
            0:  sie_in_tok = 1;
            1:  begin cpu_in_arm = 1; cpu_in_cnt = arg[6:0]; end
            2:  begin cpu_in_wr = 1; cpu_in_wdata = arg[7:0]; end
            3:  sie_host_ack = 1;
            4:  sie_host_tmo = 1;
            5:  sie_tx_rd = 1;
            6:  begin sie_rx_valid = 1; sie_rx_setup = 0; sie_rx_byte = arg[7:0]; end
            7:  begin sie_out_end = 1; sie_out_ok = arg[1]; sie_out_pid = arg[0]; end
            8:  cpu_out_rd = 1;
            9:  cpu_out_clr = 1;
            10: begin sie_rx_valid = 1; sie_rx_setup = 1; sie_rx_byte = arg[7:0]; end
            11: begin sie_setup_end = 1; sie_setup_ok = arg[0]; end
            12: sie_status_tok = 1;
            13: cpu_ackstat_set = 1;
            14: cpu_sud_rd = 1;
            15: cpu_sud_clr = 1;
            16: cpu_clr_in_tog = 1;
            17: cpu_clr_out_tog = 1;
            default: ;
        endcase
        @(negedge clk);
        sie_in_tok = 0; cpu_in_arm = 0; cpu_in_wr = 0; sie_host_ack = 0; sie_host_tmo = 0;
        sie_tx_rd = 0; sie_rx_valid = 0; sie_rx_setup = 0; sie_out_end = 0; sie_out_ok = 0;
        sie_out_pid = 0; cpu_out_rd = 0; cpu_out_clr = 0; sie_setup_end = 0; sie_setup_ok = 0;
        sie_status_tok = 0; cpu_ackstat_set = 0; cpu_sud_rd = 0; cpu_sud_clr = 0;
        cpu_clr_in_tog = 0; cpu_clr_out_tog = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(in_bav == 1 && out_dav == 0 && sud_av == 0, "R1 requests", {in_bav, out_dav, sud_av}, 3'b100);
        chk(in_tog == 0 && out_tog == 0 && ackstat == 0 && hs_valid == 0, "R1 toggles",
            {in_tog, out_tog, ackstat, hs_valid}, 0);
        // R3 unarmed IN
        op(0, 0);
        chk(hs_valid && hs_code == 2, "R3 nak unarmed", hs_code, 2);
        // R2 load and arm
        for (int k = 0; k < 5; k++) op(2, 8'h10 + k);
        op(1, 5);
        chk(in_bav == 0, "R2 arm clears bav", in_bav, 0);
        op(0, 0);
        chk(hs_valid && hs_code == 1 && tx_len == 5 && tx_tog == 0, "R2 data answer", {hs_code, tx_len}, {2'd1, 7'd5});
        for (int k = 0; k < 5; k++) begin
            chk(tx_byte == 8'h10 + k, "R2 byte order", tx_byte, 8'h10 + k);
            op(5, 0);
        end
        // R5 timeout and resend; R6 stray load while armed
        op(4, 0);
        op(2, 8'hEE);
        op(0, 0);
        chk(hs_valid && hs_code == 1 && tx_tog == 0 && tx_len == 5, "R5 resend", hs_code, 1);
        for (int k = 0; k < 5; k++) begin
            chk(tx_byte == 8'h10 + k, "R6 data kept", tx_byte, 8'h10 + k);
            op(5, 0);
        end
        // R4 host ack
        op(3, 0);
        chk(in_bav == 1 && in_tog == 1, "R4 ack frees", {in_bav, in_tog}, 2'b11);
        op(0, 0);
        chk(hs_valid && hs_code == 2, "R3 nak after ack", hs_code, 2);
        // R13 clear IN toggle
        op(16, 0);
        chk(in_tog == 0, "R13 in toggle clear", in_tog, 0);
        // R2 full buffer, count clamp
        for (int k = 0; k < 64; k++) op(2, k ^ 8'h5A);
        op(1, 100);
        op(0, 0);
        chk(tx_len == 64, "R2 length clamp", tx_len, 64);
        for (int k = 0; k < 64; k++) begin
            chk(tx_byte == (k ^ 8'h5A), "R2 full buffer", tx_byte, k ^ 8'h5A);
            op(5, 0);
        end
        op(3, 0);
        // R7 good OUT
        for (int k = 0; k < 4; k++) op(6, 8'hA0 + k);
        op(7, 2'b10);
        chk(hs_valid && hs_code == 3 && out_dav && out_cnt == 4 && out_tog == 1, "R7 accept",
            {hs_code, out_cnt}, {2'd3, 7'd4});
        // R10 OUT while held
        for (int k = 0; k < 3; k++) op(6, 8'hB0 + k);
        op(7, 2'b11);
        chk(hs_valid && hs_code == 2 && out_dav && out_cnt == 4, "R10 nak held", {hs_code, out_cnt}, {2'd2, 7'd4});
        for (int k = 0; k < 4; k++) begin
            chk(out_rdata == 8'hA0 + k, "R10 data preserved", out_rdata, 8'hA0 + k);
            op(8, 0);
        end
        op(9, 0);
        chk(out_dav == 0, "R10 clear rearms", out_dav, 0);
        // R8 bad OUT
        op(6, 1); op(6, 2);
        op(7, 2'b01);
        chk(!hs_valid && !out_dav && out_tog == 1, "R8 bad silent", {hs_valid, out_dav, out_tog}, 3'b001);
        // R9 repeated toggle
        op(6, 8'h33);
        op(7, 2'b10);
        chk(hs_valid && hs_code == 3 && !out_dav && out_tog == 1, "R9 duplicate", {hs_code, out_dav}, {2'd3, 1'b0});
        // R7 zero-length, then R13 clear OUT toggle
        op(7, 2'b11);
        chk(out_dav && out_cnt == 0 && out_tog == 0, "R7 zero length", out_cnt, 0);
        op(9, 0);
        op(7, 2'b10);
        op(9, 0);
        chk(out_tog == 1, "R7 toggle flips", out_tog, 1);
        op(17, 0);
        chk(out_tog == 0, "R13 out toggle clear", out_tog, 0);
        // R11 setup
        for (int k = 0; k < 8; k++) op(10, 8'h80 + k);
        op(11, 1);
        chk(hs_valid && hs_code == 3 && sud_av && !ackstat, "R11 setup ack", {hs_code, sud_av}, {2'd3, 1'b1});
        for (int k = 0; k < 8; k++) begin
            chk(sud_rdata == 8'h80 + k, "R11 setup bytes", sud_rdata, 8'h80 + k);
            op(14, 0);
        end
        // R12 status stage
        op(12, 0);
        chk(hs_valid && hs_code == 2, "R12 nak before grant", hs_code, 2);
        op(13, 0);
        chk(ackstat == 1, "R12 grant", ackstat, 1);
        op(12, 0);
        chk(hs_valid && hs_code == 3 && ackstat == 0, "R12 ack and self clear", {hs_code, ackstat}, {2'd3, 1'b0});
        op(12, 0);
        chk(hs_valid && hs_code == 2, "R12 nak after use", hs_code, 2);
        op(15, 0);
        chk(sud_av == 0, "R11 setup clear", sud_av, 0);
        // random single events compared against the model
        for (int i = 0; i < 4000; i++) begin
            int kind;
            kind = $urandom_range(0, 18);
            op(kind, $urandom_range(0, 255));
        end
        @(negedge clk);
        finish_run();
    end
endmodule